// File: doc/BRIEF.md
# Data Parity Error Reporter

This block watches the data phases of a PCI-style bus in which this agent is the receiver. The receiver is the target of a write or the initiator of a read. For each such phase it checks even parity over the address/data lines and the byte-enable lines against the parity bit. The parity bit arrives one clock after the data it covers.

When the check fails, the block pulls the active-low parity-error line low. This happens exactly two clocks after the data and one clock after the parity bit. It also raises a one-cycle status pulse.

The block drives the error line only while it owns it. Ownership covers the result cycle of each checked phase. After the last driven cycle the line is held high for one more cycle and then released to the external pull-up.

A response-enable input gates only the line driving. The status pulse is reported whether or not the response is enabled.

Top module: `par_err_reporter`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `perr_n` is 1, `perr_oe` is 0 and `err_det` is 0.
- R2: A phase is in error when the XOR of all bits of `ad`, all bits of `cbe_n` and the `par` bit of the following cycle is 1. This is even parity, with `par` arriving one cycle after the data it covers.
- R3: A data phase is checked only when `data_vld` and `rx_role` are both 1 in its `ad` cycle. Other phases never raise `err_det`, never pull `perr_n` low and never assert `perr_oe`.
- R4: For a checked phase in error with `ad` in cycle N, `err_det` is 1 and `perr_n` is 0 in cycle N+2 only, which is one cycle after its `par`.
- R5: For every checked phase with `par_resp_en` = 1 in cycle N+1, `perr_oe` is 1 in cycle N+2. `perr_n` is 1 in that cycle when the parity is correct.
- R6: In the cycle after the last cycle driven under R5, `perr_oe` stays 1 with `perr_n` = 1. In the cycle after that, `perr_oe` is 0.
- R7: With `par_resp_en` = 0 in cycle N+1, a failing phase still pulses `err_det` in cycle N+2. `perr_n` stays 1 and `perr_oe` stays 0 for that phase.
- R8: Back-to-back checked phases are each judged on their own data and parity. `perr_oe` stays 1 across them without a park gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ad | input | 32 | Address/data lines for the current data phase |
| cbe_n | input | 4 | Command/byte-enable lines for the current data phase |
| par | input | 1 | Parity bit covering the previous cycle's `ad` and `cbe_n` |
| data_vld | input | 1 | Data actually transfers this cycle |
| rx_role | input | 1 | This agent receives the data (target of a write or initiator of a read) |
| par_resp_en | input | 1 | Parity error response enable, sampled with `par` |
| perr_n | output | 1 | Active-low parity error line value |
| perr_oe | output | 1 | Output enable for `perr_n` |
| err_det | output | 1 | One-cycle parity error detected pulse |

## Verification
The check is tried with correct parity, with a single flipped bit in each of several `ad` positions, with a flipped byte-enable bit and with a flipped `par` bit. This separates a correct reduction over all 37 bits from one that misses a lane or compares in the wrong cycle. The same failing pattern is replayed with the agent not receiving and with `data_vld` low. This separates role qualification from plain detection. Isolated phases are contrasted with back-to-back bursts and with the enable cleared. This tells the one-cycle park apart from continuous ownership, and response gating apart from status reporting.

// File: rtl/pdr_pkg.sv
package pdr_pkg;

    // Driver ownership of the error line in the current cycle
    typedef enum logic [1:0] {
        DRV_OFF  = 2'd0,
        DRV_ON   = 2'd1,
        DRV_PARK = 2'd2
    } drv_state_e;

    // First pipeline stage: qualified phase and folded parity of data lanes
    typedef struct packed {
        logic chk;
        logic calc;
    } cap_t;

    // Second pipeline stage: verdict for the result cycle
    typedef struct packed {
        logic drive;
        logic err;
    } res_t;

    // Even parity over data and byte lanes plus PAR must fold to zero
    function automatic logic parity_fail(input logic calc, input logic par_bit);
        return calc ^ par_bit;
    endfunction

endpackage

// File: rtl/pdr_capture.sv
module pdr_capture
    import pdr_pkg::*;
#(
    parameter int AD_W = 32,
    parameter int BE_W = AD_W / 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AD_W-1:0] ad,
    input  logic [BE_W-1:0] cbe_n,
    input  logic            data_vld,
    input  logic            rx_role,
    output cap_t            cap_q
);

    cap_t cap_d;

    always_comb begin
        cap_d.chk  = data_vld & rx_role;
        cap_d.calc = (^ad) ^ (^cbe_n);
    end

    always_ff @(posedge clk) begin
        if (rst) cap_q <= '0;
        else     cap_q <= cap_d;
    end

endmodule

// File: rtl/pdr_check.sv
module pdr_check
    import pdr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cap_t cap_i,
    input  logic par,
    input  logic par_resp_en,
    output res_t res_q
);

    res_t res_d;

    always_comb begin
        res_d.err   = cap_i.chk & parity_fail(cap_i.calc, par);
        res_d.drive = cap_i.chk & par_resp_en;
    end

    always_ff @(posedge clk) begin
        if (rst) res_q <= '0;
        else     res_q <= res_d;
    end

    // R3: a verdict exists only for a phase qualified one cycle earlier
    a_r3_err_needs_chk : assert property (@(posedge clk) disable iff (rst)
        res_q.err |-> $past(cap_i.chk));

    // R7: ownership only when the enable was set with PAR
    a_r7_drive_needs_en : assert property (@(posedge clk) disable iff (rst)
        res_q.drive |-> $past(par_resp_en));

endmodule

// File: rtl/pdr_drive.sv
module pdr_drive
    import pdr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  res_t       res_i,
    output logic       perr_n,
    output logic       perr_oe,
    output drv_state_e state
);

    logic owned_q;

    always_ff @(posedge clk) begin
        if (rst) owned_q <= 1'b0;
        else     owned_q <= res_i.drive;
    end

    always_comb begin
        if (res_i.drive)  state = DRV_ON;
        else if (owned_q) state = DRV_PARK;
        else              state = DRV_OFF;
    end

    assign perr_oe = (state != DRV_OFF);
    assign perr_n  = !((state == DRV_ON) && res_i.err);

    // R6: the park cycle always drives the line high
    a_r6_park_high : assert property (@(posedge clk) disable iff (rst)
        (state == DRV_PARK) |-> (perr_oe && perr_n));

    // R6: park lasts one cycle unless a new phase takes the line
    a_r6_park_once : assert property (@(posedge clk) disable iff (rst)
        (state == DRV_PARK) |=> (state != DRV_PARK));

endmodule

// File: rtl/par_err_reporter.sv
module par_err_reporter
    import pdr_pkg::*;
#(
    parameter int AD_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [AD_W-1:0]       ad,
    input  logic [AD_W/8-1:0]     cbe_n,
    input  logic                  par,
    input  logic                  data_vld,
    input  logic                  rx_role,
    input  logic                  par_resp_en,
    output logic                  perr_n,
    output logic                  perr_oe,
    output logic                  err_det
);

    localparam int BE_W = AD_W / 8;

    cap_t       cap;
    res_t       res;
    drv_state_e drv_state;

    pdr_capture #(.AD_W(AD_W), .BE_W(BE_W)) u_capture (
        .clk      (clk),
        .rst      (rst),
        .ad       (ad),
        .cbe_n    (cbe_n),
        .data_vld (data_vld),
        .rx_role  (rx_role),
        .cap_q    (cap)
    );

    pdr_check u_check (
        .clk         (clk),
        .rst         (rst),
        .cap_i       (cap),
        .par         (par),
        .par_resp_en (par_resp_en),
        .res_q       (res)
    );

    pdr_drive u_drive (
        .clk     (clk),
        .rst     (rst),
        .res_i   (res),
        .perr_n  (perr_n),
        .perr_oe (perr_oe),
        .state   (drv_state)
    );

    assign err_det = res.err;

    // R4: a low error line is always owned
    a_r4_low_is_driven : assert property (@(posedge clk) disable iff (rst)
        !perr_n |-> perr_oe);

    // R3, R4: a pulse follows a receiving data phase two cycles back
    a_r4_det_timing : assert property (@(posedge clk) disable iff (rst)
        err_det |-> $past(data_vld && rx_role, 2));

    // R7: a low line needs the enable from the PAR cycle
    a_r7_low_needs_en : assert property (@(posedge clk) disable iff (rst)
        !perr_n |-> $past(par_resp_en));

    // R6: release happens only after a high driven cycle
    a_r6_release_high : assert property (@(posedge clk) disable iff (rst)
        $fell(perr_oe) |-> $past(perr_n));

endmodule

// File: tb/par_err_reporter_tb.sv
module par_err_reporter_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] ad;
    logic [3:0]  cbe_n;
    logic        par;
    logic        data_vld;
    logic        rx_role;
    logic        par_resp_en;
    logic        perr_n;
    logic        perr_oe;
    logic        err_det;

    int total = 0;
    int bad   = 0;

    // Behavioural model history (one entry per previous cycle)
    logic m_chk_prev  = 1'b0;
    logic m_fold_prev = 1'b0;
    logic m_drv_prev  = 1'b0;
    // Parity a correct sender would put on PAR next cycle, and planned flip
    logic nxt_good_par = 1'b0;
    logic nxt_flip     = 1'b0;

    always #10 clk = ~clk;

    par_err_reporter u_dut (
        .clk(clk), .rst(rst), .ad(ad), .cbe_n(cbe_n), .par(par),
        .data_vld(data_vld), .rx_role(rx_role), .par_resp_en(par_resp_en),
        .perr_n(perr_n), .perr_oe(perr_oe), .err_det(err_det)
    );

    initial begin
        #(20 * 200000);
        bad   = bad + 1;
        total = total + 1;
        $display("FAIL watchdog: run did not finish (actual=hung expected=done)");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // One cycle: present a data phase, PAR for the previous one, then compare
    task automatic cyc(input logic r, input logic [31:0] a, input logic [3:0] be,
                       input logic v, input logic role, input logic en,
                       input logic flip_this, input string tag);
        logic e_det, e_n, e_oe, drv, err, park;
        rst         = r;
        ad          = a;
        cbe_n       = be;
        data_vld    = v;
        rx_role     = role;
        par_resp_en = en;
        par         = nxt_good_par ^ nxt_flip;
        @(posedge clk);
        if (r) begin
            err = 0; drv = 0; park = 0;
            m_chk_prev = 0; m_drv_prev = 0;
        end else begin
            err  = m_chk_prev && (m_fold_prev ^ par);
            drv  = m_chk_prev && en;
            park = m_drv_prev && !drv;
            m_chk_prev = v && role;
            m_drv_prev = drv;
        end
        m_fold_prev  = (^a) ^ (^be);
        nxt_good_par = m_fold_prev;
        nxt_flip     = flip_this;
        e_det = err;
        e_oe  = drv || park;
        e_n   = !(drv && err);
        #5;
        total = total + 1;
        if (err_det !== e_det || perr_n !== e_n || perr_oe !== e_oe) begin
            bad = bad + 1;
            $display("FAIL %s: actual det=%b perr_n=%b oe=%b expected det=%b perr_n=%b oe=%b",
                     tag, err_det, perr_n, perr_oe, e_det, e_n, e_oe);
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 32'h0, 4'hF, 0, 0, 1, 0, tag);
    endtask

    initial begin
        rst = 1; ad = 0; cbe_n = 4'hF; par = 0;
        data_vld = 0; rx_role = 0; par_resp_en = 1;
        @(negedge clk);
        // R1 reset state, including garbage activity during reset
        cyc(1, 32'hFFFF_0001, 4'h0, 1, 1, 1, 1, "R1");
        cyc(1, 32'h1234_5678, 4'h3, 1, 1, 1, 0, "R1");
        cyc(0, 32'h0, 4'hF, 0, 0, 1, 0, "R1");
        idle(2, "R1");

        // R5 correct parity, single phase, then R6 park
        cyc(0, 32'hA5A5_0F0F, 4'h0, 1, 1, 1, 0, "R5");
        idle(4, "R6");

        // R2 / R4 single-bit errors across several lanes
        for (int b = 0; b < 32; b += 7) begin
            cyc(0, 32'h0000_0001 << b, 4'h5, 1, 1, 1, 1, "R2");
            idle(4, "R4");
        end
        // R2 byte-enable lane fault: sender computed parity without cbe bit 2
        cyc(0, 32'hDEAD_BEEF, 4'h4, 1, 1, 1, 1, "R2");
        idle(4, "R4");

        // R3 failing parity while not receiving, and while not valid
        cyc(0, 32'h1111_0000, 4'h1, 1, 0, 1, 1, "R3");
        idle(3, "R3");
        cyc(0, 32'h2222_0000, 4'h2, 0, 1, 1, 1, "R3");
        idle(3, "R3");

        // R7 enable clear in the PAR cycle: status only
        cyc(0, 32'h0F0F_0F0F, 4'h8, 1, 1, 1, 1, "R7");
        cyc(0, 32'h0, 4'hF, 0, 0, 0, 0, "R7");
        idle(3, "R7");

        // R8 back-to-back burst with errors inside, ends with R6 park
        for (int k = 0; k < 6; k++)
            cyc(0, 32'h1357_9BDF + k, 4'(k), 1, 1, 1, (k == 2 || k == 3), "R8");
        idle(4, "R6");

        // R8 burst where enable drops mid-way: gap gives a park
        cyc(0, 32'hCAFE_0001, 4'h0, 1, 1, 1, 1, "R8");
        cyc(0, 32'hCAFE_0002, 4'h0, 1, 1, 1, 0, "R8");
        cyc(0, 32'hCAFE_0003, 4'h0, 1, 1, 0, 1, "R7");
        cyc(0, 32'hCAFE_0004, 4'h0, 1, 1, 1, 0, "R6");
        idle(4, "R6");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule